// File: doc/BRIEF.md
# Serial Port Register Core

This block is a compact asynchronous serial port that a host drives through a byte-wide register window. A 3-bit offset, a write strobe and a read strobe reach the registers, and the block answers only when three chip selects agree. Inside are a line control register, a 16-bit clock divisor, a baud tick generator running at sixteen times the bit rate, a single transmit holding byte that feeds a shift register, and a receiver that keeps one received byte together with its status flags. An active-high interrupt line signals received data and an empty transmit holding register.

The divisor shares offsets 0 and 1 with the data and interrupt-enable registers. The top bit of the line control register selects which bank those two offsets reach. The bit rate is the clock frequency divided by sixteen times the divisor. For example, a divisor of 12 with a 1.8432 MHz clock gives 9600 bit/s. A typical start-up sets the bank bit, writes the two divisor bytes, then writes the frame format with the bank bit cleared. After that, writes to offset 0 transmit and reads from offset 0 collect received bytes.

Top module: `uart_regcore`

## Requirements
- R1: A register access takes effect only while sel_hi is 1, sel_lo is 0 and sel_n is 0. Under any other select combination a write changes no register.
- R2: The line control register is at offset 3. It is read and written as a full 8-bit value.
- R3: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. While bit 7 is 0, offset 0 is the data register and offset 1 is the interrupt enable register.
- R4: One serial bit lasts 16 times the divisor clock cycles.
- R5: A transmitted frame is a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits, and the line stays high when idle. The line control fields are: bits [1:0] set the word length (00=5, 01=6, 10=7, 11=8), bit 2 selects two stop bits, bit 3 enables parity and bit 4 selects even parity (0 selects odd).
- R6: Line status (offset 5) bit 5 is 1 when the transmit holding byte is empty. Bit 6 is 1 when both the holding byte and the shifter are empty. A write to offset 0 with bit 7 of line control clear fills the holding byte.
- R7: A received frame sets line status bit 0 (data ready) and stores the byte. A read of offset 0 with the bank bit clear returns that byte and clears bit 0.
- R8: The start bit is sampled 8 ticks after the falling edge. A low pulse that has ended by then is ignored.
- R9: Line status bit 1 (overrun) is set when a byte arrives while data ready is set, and the new byte replaces the old. Bit 2 flags a parity mismatch and bit 3 flags a low stop bit. Reading line status clears bits 1 to 3.
- R10: The interrupt enable register at offset 1 holds bit 0 (received data) and bit 1 (holding byte empty). irq is the registered OR of the enabled conditions.
- R11: Reset clears the line control register, the interrupt enables and all receive flags. It sets sout high and irq low.
- R12: Read data is registered: it appears in the cycle after the read strobe and holds until the next selected read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the baud reference |
| rst | input | 1 | Synchronous reset, active high |
| sel_hi | input | 1 | Select that must be high |
| sel_lo | input | 1 | Select that must be low |
| sel_n | input | 1 | Active-low select |
| addr | input | 3 | Register offset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sin | input | 1 | Serial receive line |
| sout | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt, active high |

## Verification
The receive error flags are the hardest state to reach, because the ports expose them only after a complete frame with exact bit timing. The bench drives sin itself, one bit every 16-divisor cycles, and builds deliberately bad frames. It sends a frame whose stop bit stays low, a frame with the wrong parity bit, two frames back to back with no read between them, and a low pulse shorter than half a bit. After each, it reads line status to check the flags and confirms that a second status read finds them cleared.

// File: rtl/urc_pkg.sv
package urc_pkg;
  localparam int DIV_W = 16;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_LSTAT = 3'd5;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_st_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_st_t;

  // mask of the valid data bits for a word length code
  function automatic logic [7:0] wl_mask(input logic [1:0] wl);
    case (wl)
      2'd0:    wl_mask = 8'h1F;
      2'd1:    wl_mask = 8'h3F;
      2'd2:    wl_mask = 8'h7F;
      default: wl_mask = 8'hFF;
    endcase
  endfunction

  // right-justify a byte shifted in from the top
  function automatic logic [7:0] wl_align(input logic [7:0] sh, input logic [1:0] wl);
    case (wl)
      2'd0:    wl_align = {3'b000, sh[7:3]};
      2'd1:    wl_align = {2'b00, sh[7:2]};
      2'd2:    wl_align = {1'b0, sh[7:1]};
      default: wl_align = sh;
    endcase
  endfunction
endpackage

// File: rtl/urc_baud.sv
module urc_baud #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R4: with a divisor above one, ticks never come on consecutive cycles
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && div > 1) |=> (!tick || !$stable(div)))
    else $error("tick spacing");
endmodule

// File: rtl/urc_tx.sv
module urc_tx import urc_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] wl,
  input  logic       two_stop,
  input  logic       pen,
  input  logic       even,
  input  logic       thr_full,
  input  logic [7:0] thr_data,
  output logic       take,
  output logic       idle,
  output logic       sout
);
  localparam int CW = $clog2(OVS);

  tx_st_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn, nbm1;
  logic          pen_q, par_q, two_q, stopn;
  logic          last;

  assign last = (cnt == CW'(OVS - 1));
  assign take = (st == TX_IDLE) && thr_full;
  assign idle = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      sout  <= 1'b1;
      cnt   <= '0;
      sh    <= '0;
      bitn  <= '0;
      nbm1  <= '0;
      pen_q <= 1'b0;
      par_q <= 1'b0;
      two_q <= 1'b0;
      stopn <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (thr_full) begin
          sh    <= thr_data;
          nbm1  <= 3'd4 + {1'b0, wl};
          pen_q <= pen;
          two_q <= two_stop;
          par_q <= even ? ^(thr_data & wl_mask(wl)) : ~^(thr_data & wl_mask(wl));
          sout  <= 1'b0;
          cnt   <= '0;
          st    <= TX_START;
        end
        TX_START: if (tick) begin
          if (last) begin
            cnt  <= '0;
            sout <= sh[0];
            sh   <= {1'b0, sh[7:1]};
            bitn <= '0;
            st   <= TX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        TX_DATA: if (tick) begin
          if (last) begin
            cnt <= '0;
            if (bitn == nbm1) begin
              if (pen_q) begin
                sout <= par_q;
                st   <= TX_PAR;
              end else begin
                sout  <= 1'b1;
                stopn <= 1'b0;
                st    <= TX_STOP;
              end
            end else begin
              sout <= sh[0];
              sh   <= {1'b0, sh[7:1]};
              bitn <= bitn + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        TX_PAR: if (tick) begin
          if (last) begin
            cnt   <= '0;
            sout  <= 1'b1;
            stopn <= 1'b0;
            st    <= TX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        TX_STOP: if (tick) begin
          if (last) begin
            cnt <= '0;
            if (stopn == two_q) st <= TX_IDLE;
            else stopn <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R5: loading the shifter starts a low start bit on the next cycle
  assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> !sout)
    else $error("start bit not low");
endmodule

// File: rtl/urc_rx.sv
module urc_rx import urc_pkg::*; #(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] wl,
  input  logic       pen,
  input  logic       even,
  input  logic       sin,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       rx_fe,
  output logic       rx_pe
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [SYNC-1:0] sy;
  logic            cur, prev;
  rx_st_t          st;
  logic [CW-1:0]   cnt;
  logic [7:0]      sh, al;
  logic [2:0]      bitn, nbm1;
  logic [1:0]      wl_q;
  logic            pen_q, even_q, par_bit, ones;

  assign cur  = sy[SYNC-1];
  assign al   = wl_align(sh, wl_q);
  assign ones = ^al ^ par_bit;

  generate
    if (SYNC > 1) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= {sy[SYNC-2:0], sin};
      end
    end else begin : g_nosync
      always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= sin;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      prev    <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      bitn    <= '0;
      nbm1    <= '0;
      wl_q    <= '0;
      pen_q   <= 1'b0;
      even_q  <= 1'b0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
      rx_fe   <= 1'b0;
      rx_pe   <= 1'b0;
    end else begin
      prev <= cur;
      done <= 1'b0;
      case (st)
        RX_IDLE: if (prev && !cur) begin
          cnt    <= '0;
          wl_q   <= wl;
          nbm1   <= 3'd4 + {1'b0, wl};
          pen_q  <= pen;
          even_q <= even;
          st     <= RX_START;
        end
        RX_START: if (tick) begin
          if (cnt == CW'(MID - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= cur ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (cnt == CW'(OVS - 1)) begin
            cnt  <= '0;
            sh   <= {cur, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == nbm1) st <= pen_q ? RX_PAR : RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_PAR: if (tick) begin
          if (cnt == CW'(OVS - 1)) begin
            cnt     <= '0;
            par_bit <= cur;
            st      <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (cnt == CW'(OVS - 1)) begin
            cnt     <= '0;
            done    <= 1'b1;
            rx_data <= al;
            rx_fe   <= !cur;
            rx_pe   <= pen_q && (even_q ? ones : !ones);
            st      <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8: a start pulse that is high again at mid-bit drops back to idle
  assert_glitch_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && tick && cnt == CW'(MID - 1) && cur) |=> (st == RX_IDLE))
    else $error("false start accepted");
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore import urc_pkg::*; #(
  parameter int DIV_RESET = 12,
  parameter int OVS       = 16,
  parameter int SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_hi,
  input  logic       sel_lo,
  input  logic       sel_n,
  input  logic [2:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sin,
  output logic       sout,
  output logic       irq
);
  logic [7:0]       lcr, dll, dlm, thr, rbr, lsr;
  logic [1:0]       ier;
  logic             thr_full, dr, oe, fe, pe;
  logic             sel, wr_en, rd_en, dlab, rd_rbr, rd_lsr, thre, temt;
  logic             tick, take, tx_idle, rx_done, rx_fe, rx_pe;
  logic [7:0]       rx_byte;
  logic [DIV_W-1:0] divisor;

  assign sel     = sel_hi & ~sel_lo & ~sel_n;
  assign wr_en   = sel & wr;
  assign rd_en   = sel & rd;
  assign dlab    = lcr[7];
  assign rd_rbr  = rd_en && (addr == OFS_DATA) && !dlab;
  assign rd_lsr  = rd_en && (addr == OFS_LSTAT);
  assign thre    = !thr_full;
  assign temt    = !thr_full && tx_idle;
  assign lsr     = {1'b0, temt, thre, 1'b0, fe, pe, oe, dr};
  assign divisor = {dlm, dll};

  urc_baud #(.DW(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(divisor), .tick(tick)
  );

  urc_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .wl(lcr[1:0]), .two_stop(lcr[2]), .pen(lcr[3]), .even(lcr[4]),
    .thr_full(thr_full), .thr_data(thr),
    .take(take), .idle(tx_idle), .sout(sout)
  );

  urc_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst(rst), .tick(tick),
    .wl(lcr[1:0]), .pen(lcr[3]), .even(lcr[4]), .sin(sin),
    .done(rx_done), .rx_data(rx_byte), .rx_fe(rx_fe), .rx_pe(rx_pe)
  );

  // host-written registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr      <= '0;
      ier      <= '0;
      {dlm, dll} <= DIV_W'(DIV_RESET);
      thr      <= '0;
      thr_full <= 1'b0;
    end else begin
      if (take) thr_full <= 1'b0;
      if (wr_en) begin
        case (addr)
          OFS_DATA: begin
            if (dlab) dll <= wdata;
            else begin
              thr      <= wdata;
              thr_full <= 1'b1;
            end
          end
          OFS_IEN: begin
            if (dlab) dlm <= wdata;
            else      ier <= wdata[1:0];
          end
          OFS_LCTL: lcr <= wdata;
          default: ;
        endcase
      end
    end
  end

  // receive buffer and status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rbr <= '0;
      dr  <= 1'b0;
      oe  <= 1'b0;
      fe  <= 1'b0;
      pe  <= 1'b0;
    end else begin
      if (rd_rbr) dr <= 1'b0;
      if (rd_lsr) begin
        oe <= 1'b0;
        fe <= 1'b0;
        pe <= 1'b0;
      end
      if (rx_done) begin
        rbr <= rx_byte;
        dr  <= 1'b1;
        if (dr && !rd_rbr) oe <= 1'b1;
        if (rx_fe) fe <= 1'b1;
        if (rx_pe) pe <= 1'b1;
      end
    end
  end

  // registered read port and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (ier[0] & dr) | (ier[1] & thre);
      if (rd_en) begin
        case (addr)
          OFS_DATA:  rdata <= dlab ? dll : rbr;
          OFS_IEN:   rdata <= dlab ? dlm : {6'b0, ier};
          OFS_LCTL:  rdata <= lcr;
          OFS_LSTAT: rdata <= lsr;
          default:   rdata <= '0;
        endcase
      end
    end
  end

  assert_unselected_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr && !sel) |=> ($stable(lcr) && $stable(ier) && $stable(divisor)))
    else $error("write without select took effect");

  assert_thr_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DATA && !dlab) |=> !thre)
    else $error("holding byte not filled");

  assert_dr_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_rbr && !rx_done) |=> !dr)
    else $error("data ready not cleared");

  assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && dr && !rd_rbr) |=> oe)
    else $error("overrun not flagged");

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(ier) == 2'b00) |-> !irq)
    else $error("irq with no enables");

  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sout && !irq))
    else $error("outputs not idle after reset");
endmodule

// File: tb/uart_regcore_bench.sv
module uart_regcore_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIVISOR    = 2;
  localparam int BITCLK     = DIVISOR * 16;
  localparam int NV         = 15;
  // {read, addr[2:0], wdata[7:0], expected[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 3'd3, 8'h83, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h83},
    {1'b0, 3'd0, 8'h02, 8'h00},
    {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h02},
    {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b0, 3'd3, 8'h03, 8'h00},
    {1'b1, 3'd3, 8'h00, 8'h03},
    {1'b0, 3'd1, 8'h03, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h03},
    {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_hi = 1'b0, sel_lo = 1'b1, sel_n = 1'b1;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sin = 1'b1;
  logic       sout, irq;
  int         nchk = 0, nfail = 0;
  bit         ended = 1'b0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regcore u_uart_regcore (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .sel_n(sel_n),
    .addr(addr), .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata),
    .sin(sin), .sout(sout), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic wr_sel(input logic [2:0] a, input logic [7:0] d,
                        input logic h, input logic l, input logic n);
    @(negedge clk);
    sel_hi = h; sel_lo = l; sel_n = n;
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; sel_hi = 1'b0; sel_lo = 1'b1; sel_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    wr_sel(a, d, 1'b1, 1'b0, 1'b0);
  endtask

  // R12: the value is taken at the negedge after the capturing edge
  task automatic rd_sel(input logic [2:0] a, output logic [7:0] v,
                        input logic h, input logic l, input logic n);
    @(negedge clk);
    sel_hi = h; sel_lo = l; sel_n = n;
    addr = a; rd = 1'b1;
    @(negedge clk);
    v = rdata;
    rd = 1'b0; sel_hi = 1'b0; sel_lo = 1'b1; sel_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    rd_sel(a, v, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic [7:0] lc, input string req);
    int nb, ns;
    logic [7:0] md;
    logic pb;
    nb = 5 + int'(lc[1:0]);
    ns = lc[2] ? 2 : 1;
    md = d & (8'hFF >> (8 - nb));
    pb = lc[4] ? ^md : ~^md;
    wr_reg(3'd0, d);
    @(negedge sout);
    repeat (BITCLK/2) @(posedge clk);
    #1 chk({req, " start bit"}, {7'b0, sout}, 8'h00);
    for (int i = 0; i < nb; i++) begin
      repeat (BITCLK) @(posedge clk);
      #1 chk($sformatf("%s data bit %0d", req, i), {7'b0, sout}, {7'b0, md[i]});
    end
    if (lc[3]) begin
      repeat (BITCLK) @(posedge clk);
      #1 chk({req, " parity bit"}, {7'b0, sout}, {7'b0, pb});
    end
    for (int s = 0; s < ns; s++) begin
      repeat (BITCLK) @(posedge clk);
      #1 chk($sformatf("%s stop bit %0d", req, s), {7'b0, sout}, 8'h01);
    end
    repeat (BITCLK) @(posedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input int nb, input logic pen,
                         input logic pb, input logic stopv);
    @(negedge clk);
    sin = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sin = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (pen) begin
      sin = pb;
      repeat (BITCLK) @(negedge clk);
    end
    sin = stopv;
    repeat (BITCLK) @(negedge clk);
    sin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11 sout after reset", {7'b0, sout}, 8'h01);
    chk("R11 irq after reset", {7'b0, irq}, 8'h00);

    // table walk: reset values, bank switch, divisor, enables
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        rd_reg(VEC[i][18:16], got);
        chk($sformatf("R2 R3 R10 vector %0d", i), got, VEC[i][7:0]);
      end else begin
        wr_reg(VEC[i][18:16], VEC[i][15:8]);
      end
    end

    // R1: writes with a wrong select are ignored
    wr_sel(3'd3, 8'h1F, 1'b0, 1'b0, 1'b0);
    wr_sel(3'd3, 8'h1F, 1'b1, 1'b1, 1'b0);
    wr_sel(3'd3, 8'h1F, 1'b1, 1'b0, 1'b1);
    rd_reg(3'd3, got);
    chk("R1 line control after unselected writes", got, 8'h03);
    // R12: unselected read leaves the read data unchanged
    rd_sel(3'd5, got, 1'b0, 1'b0, 1'b0);
    chk("R12 rdata held on unselected read", got, 8'h03);

    // R4: a low data bit inside a frame lasts 16 * divisor cycles
    wr_reg(3'd0, 8'hA5);
    @(negedge sout);
    @(posedge sout);
    @(negedge sout);
    n = 0;
    while (sout == 1'b0 && n < 1000) begin
      @(posedge clk);
      #1 n++;
    end
    chk("R4 bit period", 8'(n), 8'(BITCLK));
    repeat (BITCLK * 10) @(posedge clk);

    // R5: frame formats
    tx_frame(8'hA5, 8'h03, "R5 8N1");
    wr_reg(3'd3, 8'h1A);
    tx_frame(8'h53, 8'h1A, "R5 7E1");
    wr_reg(3'd3, 8'h0C);
    tx_frame(8'h17, 8'h0C, "R5 5O2");
    wr_reg(3'd3, 8'h03);
    chk("R5 idle line high", {7'b0, sout}, 8'h01);

    // R6: holding byte and shifter status
    wr_reg(3'd0, 8'h11);
    wr_reg(3'd0, 8'h22);
    rd_reg(3'd5, got);
    chk("R6 both full", got & 8'h60, 8'h00);
    repeat (BITCLK * 22) @(posedge clk);
    rd_reg(3'd5, got);
    chk("R6 both empty", got & 8'h60, 8'h60);

    // R10: holding-empty interrupt
    wr_reg(3'd1, 8'h02);
    repeat (2) @(negedge clk);
    chk("R10 irq on holding empty", {7'b0, irq}, 8'h01);
    wr_reg(3'd1, 8'h01);
    repeat (2) @(negedge clk);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);

    // R7: receive one byte with receive interrupt enabled
    rx_send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    chk("R10 irq on data ready", {7'b0, irq}, 8'h01);
    rd_reg(3'd5, got);
    chk("R7 data ready set", got, 8'h61);
    rd_reg(3'd0, got);
    chk("R7 received byte", got, 8'h5A);
    @(negedge clk);
    chk("R10 irq drops after read", {7'b0, irq}, 8'h00);
    rd_reg(3'd5, got);
    chk("R7 data ready cleared", got, 8'h60);
    wr_reg(3'd1, 8'h00);

    // R8: short low pulse is rejected
    @(negedge clk);
    sin = 1'b0;
    repeat (10) @(negedge clk);
    sin = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    rd_reg(3'd5, got);
    chk("R8 glitch ignored", got, 8'h60);

    // R9: overrun, new byte replaces old
    rx_send(8'h11, 8, 1'b0, 1'b0, 1'b1);
    rx_send(8'h22, 8, 1'b0, 1'b0, 1'b1);
    rd_reg(3'd5, got);
    chk("R9 overrun set", got, 8'h63);
    rd_reg(3'd5, got);
    chk("R9 overrun cleared by status read", got, 8'h61);
    rd_reg(3'd0, got);
    chk("R9 newer byte kept", got, 8'h22);

    // R9: framing error
    rx_send(8'h33, 8, 1'b0, 1'b0, 1'b0);
    rd_reg(3'd5, got);
    chk("R9 framing error", got, 8'h69);
    rd_reg(3'd0, got);
    chk("R9 byte with framing error", got, 8'h33);

    // R9: parity, 7 data bits even parity
    wr_reg(3'd3, 8'h1A);
    rx_send(8'h2C, 7, 1'b1, 1'b1, 1'b1);
    rd_reg(3'd5, got);
    chk("R9 good parity", got, 8'h61);
    rd_reg(3'd0, got);
    chk("R7 seven-bit byte", got, 8'h2C);
    rx_send(8'h2C, 7, 1'b1, 1'b0, 1'b1);
    rd_reg(3'd5, got);
    chk("R9 parity error", got, 8'h65);
    rd_reg(3'd5, got);
    chk("R9 parity cleared by status read", got, 8'h61);

    // R11: reset in mid-run
    wr_reg(3'd3, 8'h83);
    wr_reg(3'd1, 8'h05);
    wr_reg(3'd3, 8'h03);
    wr_reg(3'd1, 8'h03);
    wr_reg(3'd3, 8'h83);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 sout after mid reset", {7'b0, sout}, 8'h01);
    chk("R11 irq after mid reset", {7'b0, irq}, 8'h00);
    rd_reg(3'd3, got);
    chk("R11 line control cleared", got, 8'h00);
    rd_reg(3'd1, got);
    chk("R11 R3 offset 1 is enables after reset", got, 8'h00);
    rd_reg(3'd5, got);
    chk("R11 status after reset", got, 8'h60);

    finish_run();
  end
endmodule